// File: doc/BRIEF.md
# Open-Drain I2C Byte Engine

This block is an I2C master engine that works at the bit and byte level. It drives the clock and data lines only by enabling a pull to ground on each one. It never drives either line high: a released line rises through the external pull-up. A controller hands it one command at a time over a valid/ready handshake. The commands are: generate a START condition, generate a STOP condition, send a byte, or receive a byte. A received byte is either acknowledged or ended with a STOP. When the command finishes, a one-cycle done pulse returns the result: the received byte, the missing-acknowledge flag of a send, or a stuck-clock flag.

Every timed step is counted in microseconds. A divider derived from the clock frequency parameter produces these microseconds. The two line inputs pass through a two-flop synchroniser before anything reads them.

Clock stretching is handled this way. After each clock release the engine polls the clock line every 2 µs until it reads high. It gives up after twice the 500 µs limit that slow targets are allowed, records the fault and carries on. Every STOP is followed by a 60 µs bus-free wait before the engine accepts another command.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset both pull enables are off, cmdReady is high and doneValid is low.
- R2: cmdOp codes are 0 = START, 1 = STOP, 2 = send byte, 3 = receive byte with acknowledge, and 4 = receive final byte then STOP. A command is taken when cmdValid and cmdReady are both high. cmdReady stays low until the single-cycle doneValid pulse that ends the command. Codes 5 to 7 end with a done pulse and cause no line activity.
- R3: A send puts cmdData on the data line MSB first, one bit for each high phase of the clock.
- R4: On the ninth clock of a send, the data line is released. doneNack returns the level read there: 1 means no acknowledge. For every other command doneNack is 0.
- R5: A receive samples eight bits MSB first while the clock is high and returns them on doneData.
- R6: A receive with acknowledge pulls the data line low during the ninth clock and releases it before done.
- R7: A final receive leaves the data line released on the ninth clock and then generates a STOP.
- R8: A START drops the data line while the clock is high and leaves the clock pulled low. A STOP raises the data line while the clock is high. At least 60 µs pass between a STOP and the done pulse of the command that issued it.
- R9: After each release the engine waits until the synchronised clock line reads high. Stretching shorter than 1000 µs delays the transfer, does not corrupt it and sets no fault.
- R10: If the clock line is still low 1000 µs after a release, doneStuck is 1 for that command and the command still completes. The flag is cleared when the next command is accepted.
- R11: Each clock pull-low lasts at least 2 µs. At least 2 µs pass after any change of the data pull before the clock pull changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle and able to take a command |
| cmdOp | input | 3 | Command code (see R2) |
| cmdData | input | 8 | Byte to send |
| doneValid | output | 1 | One-cycle pulse at the end of a command |
| doneData | output | 8 | Received byte |
| doneNack | output | 1 | Send was not acknowledged |
| doneStuck | output | 1 | Clock line stayed low past the stretch limit |
| sclIn | input | 1 | Clock line level as seen on the bus |
| sdaIn | input | 1 | Data line level as seen on the bus |
| sclPullLow | output | 1 | Enable for the clock line pull-down |
| sdaPullLow | output | 1 | Enable for the data line pull-down |

## Verification
The checker assumes that cmdValid is raised only while cmdReady is high. It also assumes that the clock frequency gives at least two cycles per microsecond, so that the synchroniser settles within one poll interval. The bench models the bus as a wired-AND of the engine's pulls and a behavioural target. It offers each command only once the previous done pulse has been seen, and it holds the clock line low only while the engine itself keeps it low. The bench runs with four cycles per microsecond so that the 1000 µs stretch limit fits inside the run.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [2:0] {
    OP_START     = 3'd0,
    OP_STOP      = 3'd1,
    OP_WRITE     = 3'd2,
    OP_READ_ACK  = 3'd3,
    OP_READ_LAST = 3'd4
  } opKind_t;

  typedef enum logic [2:0] {
    STEP_NONE,
    STEP_SCL_LOW,
    STEP_SCL_REL,
    STEP_SDA_LOW,
    STEP_SDA_REL,
    STEP_SDA_TX,
    STEP_PAUSE,
    STEP_BUS_FREE
  } stepKind_t;

  // Strobes from the sequencer to the line datapath
  typedef struct packed {
    stepKind_t kind;
    logic      sample;
    logic      loadTx;
    logic      shiftTx;
    logic      clrStatus;
  } stepCmd_t;

endpackage

// File: rtl/i2c_eng_sync.sv
module i2c_eng_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_eng_dpath.sv
module i2c_eng_dpath
  import i2c_eng_pkg::*;
#(
  parameter int CYC_PER_US  = 100,
  parameter int STRETCH_US  = 1000,
  parameter int BUS_FREE_US = 60,
  parameter int SETTLE_US   = 2,
  parameter int PAUSE_US    = 1,
  parameter int POLL_US     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  stepCmd_t   step,
  input  logic [7:0] txData,
  input  logic       sclSync,
  input  logic       sdaSync,
  output logic       stepDone,
  output logic       sclPullLow,
  output logic       sdaPullLow,
  output logic [7:0] rxData,
  output logic       stuck
);
  localparam int DIV_W  = $clog2(CYC_PER_US) + 1;
  localparam int MAX_US = (STRETCH_US > BUS_FREE_US) ? STRETCH_US : BUS_FREE_US;
  localparam int US_W   = $clog2(MAX_US + 1) + 1;

  stepKind_t        activeKind;
  logic             sampleReq;
  logic [DIV_W-1:0] divCnt;
  logic [US_W-1:0]  usCnt, usNext, targetUs;
  logic [7:0]       txShift, rxShift;
  logic             tick, pollDue, riseOk, riseGiveUp, finish;

  always_comb begin
    tick    = (divCnt == DIV_W'(CYC_PER_US - 1));
    usNext  = usCnt + 1'b1;
    case (activeKind)
      STEP_PAUSE:    targetUs = US_W'(PAUSE_US);
      STEP_BUS_FREE: targetUs = US_W'(BUS_FREE_US);
      default:       targetUs = US_W'(SETTLE_US);
    endcase
    pollDue    = (usNext % US_W'(POLL_US)) == '0;
    riseOk     = pollDue && sclSync;
    riseGiveUp = usNext >= US_W'(STRETCH_US);
    if (activeKind == STEP_NONE || !tick) finish = 1'b0;
    else if (activeKind == STEP_SCL_REL)  finish = riseOk || riseGiveUp;
    else                                  finish = (usNext == targetUs);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeKind <= STEP_NONE;
      sampleReq  <= 1'b0;
      divCnt     <= '0;
      usCnt      <= '0;
      txShift    <= '0;
      rxShift    <= '0;
      sclPullLow <= 1'b0;
      sdaPullLow <= 1'b0;
      stuck      <= 1'b0;
      stepDone   <= 1'b0;
    end else begin
      stepDone <= 1'b0;
      if (step.clrStatus) stuck <= 1'b0;
      if (step.loadTx)       txShift <= txData;
      else if (step.shiftTx) txShift <= {txShift[6:0], 1'b0};
      if (step.kind != STEP_NONE) begin
        activeKind <= step.kind;
        sampleReq  <= step.sample;
        divCnt     <= '0;
        usCnt      <= '0;
        case (step.kind)
          STEP_SCL_LOW: sclPullLow <= 1'b1;
          STEP_SCL_REL: sclPullLow <= 1'b0;
          STEP_SDA_LOW: sdaPullLow <= 1'b1;
          STEP_SDA_REL: sdaPullLow <= 1'b0;
          STEP_SDA_TX:  sdaPullLow <= ~txShift[7];
          default: ;
        endcase
      end else if (activeKind != STEP_NONE) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) usCnt <= usNext;
        if (finish) begin
          activeKind <= STEP_NONE;
          stepDone   <= 1'b1;
          if (activeKind == STEP_SCL_REL) begin
            if (!riseOk) stuck <= 1'b1;
            if (sampleReq) rxShift <= {rxShift[6:0], sdaSync};
          end
        end
      end
    end
  end

  assign rxData = rxShift;
endmodule

// File: rtl/i2c_eng_ctrl.sv
module i2c_eng_ctrl
  import i2c_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       stepDone,
  output logic       cmdReady,
  output stepCmd_t   step,
  output logic       doneValid,
  output logic       nackSel
);
  typedef enum logic [4:0] {
    S_IDLE, S_DONE,
    S_ST_A, S_ST_B, S_ST_C, S_ST_D, S_ST_E,
    S_SP_A, S_SP_B, S_SP_C, S_SP_D, S_SP_E,
    S_WR_BIT, S_WR_RISE, S_WR_FALL,
    S_AK_REL, S_AK_RISE, S_AK_FALL,
    S_RD_REL, S_RD_RISE, S_RD_FALL,
    S_RA_LOW, S_RA_RISE, S_RA_FALL, S_RA_REL,
    S_RL_RISE
  } seqState_t;

  seqState_t state, nextState;
  logic      issued;
  logic [2:0] bitCnt;
  logic      ackRead;
  stepKind_t kindNow;

  always_comb begin
    case (state)
      S_ST_A, S_SP_D, S_AK_REL, S_RD_REL, S_RA_REL:       kindNow = STEP_SDA_REL;
      S_ST_B, S_SP_C, S_WR_RISE, S_AK_RISE, S_RD_RISE,
      S_RA_RISE, S_RL_RISE:                               kindNow = STEP_SCL_REL;
      S_ST_C, S_SP_B, S_RA_LOW:                           kindNow = STEP_SDA_LOW;
      S_ST_D:                                             kindNow = STEP_PAUSE;
      S_ST_E, S_SP_A, S_WR_FALL, S_AK_FALL, S_RD_FALL,
      S_RA_FALL:                                          kindNow = STEP_SCL_LOW;
      S_SP_E:                                             kindNow = STEP_BUS_FREE;
      S_WR_BIT:                                           kindNow = STEP_SDA_TX;
      default:                                            kindNow = STEP_NONE;
    endcase
  end

  always_comb begin
    step = '{kind: STEP_NONE, sample: 1'b0, loadTx: 1'b0, shiftTx: 1'b0, clrStatus: 1'b0};
    if (state == S_IDLE) begin
      step.loadTx    = cmdValid;
      step.clrStatus = cmdValid;
    end else if (!issued) begin
      step.kind    = kindNow;
      step.sample  = (state == S_AK_RISE) || (state == S_RD_RISE);
      step.shiftTx = (state == S_WR_FALL);
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:
        if (cmdValid) begin
          case (cmdOp)
            OP_START:     nextState = S_ST_A;
            OP_STOP:      nextState = S_SP_A;
            OP_WRITE:     nextState = S_WR_BIT;
            OP_READ_ACK,
            OP_READ_LAST: nextState = S_RD_REL;
            default:      nextState = S_DONE;
          endcase
        end
      S_DONE: nextState = S_IDLE;
      default:
        if (issued && stepDone) begin
          case (state)
            S_ST_A:    nextState = S_ST_B;
            S_ST_B:    nextState = S_ST_C;
            S_ST_C:    nextState = S_ST_D;
            S_ST_D:    nextState = S_ST_E;
            S_SP_A:    nextState = S_SP_B;
            S_SP_B:    nextState = S_SP_C;
            S_SP_C:    nextState = S_SP_D;
            S_SP_D:    nextState = S_SP_E;
            S_WR_BIT:  nextState = S_WR_RISE;
            S_WR_RISE: nextState = S_WR_FALL;
            S_WR_FALL: nextState = (bitCnt == 3'd7) ? S_AK_REL : S_WR_BIT;
            S_AK_REL:  nextState = S_AK_RISE;
            S_AK_RISE: nextState = S_AK_FALL;
            S_RD_REL:  nextState = S_RD_RISE;
            S_RD_RISE: nextState = S_RD_FALL;
            S_RD_FALL: nextState = (bitCnt != 3'd7) ? S_RD_RISE :
                                   (ackRead ? S_RA_LOW : S_RL_RISE);
            S_RA_LOW:  nextState = S_RA_RISE;
            S_RA_RISE: nextState = S_RA_FALL;
            S_RA_FALL: nextState = S_RA_REL;
            S_RL_RISE: nextState = S_SP_A;
            default:   nextState = S_DONE;
          endcase
        end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      issued  <= 1'b0;
      bitCnt  <= '0;
      ackRead <= 1'b0;
      nackSel <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) issued <= 1'b0;
      else if (state != S_IDLE && state != S_DONE) issued <= 1'b1;
      if (state == S_IDLE && cmdValid) begin
        bitCnt  <= '0;
        ackRead <= (cmdOp == OP_READ_ACK);
        nackSel <= (cmdOp == OP_WRITE);
      end else if (issued && stepDone && (state == S_WR_FALL || state == S_RD_FALL)) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign cmdReady  = (state == S_IDLE);
  assign doneValid = (state == S_DONE);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int STRETCH_US  = 1000,
  parameter int BUS_FREE_US = 60,
  parameter int SETTLE_US   = 2,
  parameter int PAUSE_US    = 1,
  parameter int POLL_US     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic [2:0] cmdOp,
  input  logic [7:0] cmdData,
  output logic       doneValid,
  output logic [7:0] doneData,
  output logic       doneNack,
  output logic       doneStuck,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclPullLow,
  output logic       sdaPullLow
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;

  stepCmd_t   step;
  logic       stepDone, nackSel, stuck;
  logic [1:0] lineSync;
  logic [7:0] rxData;

  i2c_eng_sync #(.WIDTH(2), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout(lineSync)
  );

  i2c_eng_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .stepDone(stepDone), .cmdReady(cmdReady), .step(step),
    .doneValid(doneValid), .nackSel(nackSel)
  );

  i2c_eng_dpath #(
    .CYC_PER_US(CYC_PER_US), .STRETCH_US(STRETCH_US), .BUS_FREE_US(BUS_FREE_US),
    .SETTLE_US(SETTLE_US), .PAUSE_US(PAUSE_US), .POLL_US(POLL_US)
  ) uDpath (
    .clk(clk), .rstN(rstN), .step(step), .txData(cmdData),
    .sclSync(lineSync[1]), .sdaSync(lineSync[0]), .stepDone(stepDone),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow), .rxData(rxData), .stuck(stuck)
  );

  assign doneData  = rxData;
  assign doneNack  = nackSel & rxData[0];
  assign doneStuck = stuck;
endmodule

// File: rtl/i2c_eng_checker.sv
module i2c_eng_checker #(
  parameter int CYC_PER_US  = 100,
  parameter int SETTLE_US   = 2,
  parameter int BUS_FREE_US = 60
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdReady,
  input logic doneValid,
  input logic sclPullLow,
  input logic sdaPullLow
);
  localparam int MIN_HOLD = SETTLE_US * CYC_PER_US;
  localparam int MIN_FREE = BUS_FREE_US * CYC_PER_US;
  localparam logic [31:0] SAT = 32'h7fff_ffff;

  logic [31:0] lowCnt, sdaCnt, freeCnt;
  logic        sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      sdaCnt  <= SAT;
      freeCnt <= SAT;
      sclPrev <= 1'b0;
      sdaPrev <= 1'b0;
    end else begin
      sclPrev <= sclPullLow;
      sdaPrev <= sdaPullLow;
      lowCnt  <= sclPullLow ? ((lowCnt == SAT) ? SAT : lowCnt + 1) : '0;
      sdaCnt  <= (sdaPullLow != sdaPrev) ? '0 : ((sdaCnt == SAT) ? SAT : sdaCnt + 1);
      if (sdaPrev && !sdaPullLow && !sclPullLow) freeCnt <= '0;
      else if (freeCnt != SAT) freeCnt <= freeCnt + 1;
    end
  end

  assert_scl_low_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclPullLow) |-> lowCnt >= 32'(MIN_HOLD));

  assert_sda_settle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sclPullLow != sclPrev) |-> sdaCnt >= 32'(MIN_HOLD));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  assert_bus_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> freeCnt >= 32'(MIN_FREE));
endmodule

bind i2c_byte_engine i2c_eng_checker #(
  .CYC_PER_US(CYC_PER_US), .SETTLE_US(SETTLE_US), .BUS_FREE_US(BUS_FREE_US)
) uChecker (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .doneValid(doneValid), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
);

// File: tb/i2c_byte_engine_test.sv
module i2c_byte_engine_test;
  localparam int CLK_HZ = 4_000_000;
  localparam int CPU    = CLK_HZ / 1_000_000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [7:0] cmdData = '0;
  logic       cmdReady, doneValid, doneNack, doneStuck, sclPullLow, sdaPullLow;
  logic [7:0] doneData;
  logic       slvSclLow = 1'b0;
  logic       slvSdaLow;
  logic       sclLine, sdaLine;

  assign sclLine = !(sclPullLow || slvSclLow);
  assign sdaLine = !(sdaPullLow || slvSdaLow);

  i2c_byte_engine #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdData(cmdData), .doneValid(doneValid), .doneData(doneData),
    .doneNack(doneNack), .doneStuck(doneStuck), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  // Bus target model and monitors
  int slvMode = 0;            // 0 passive, 1 receive and ack, 2 transmit
  logic [7:0] slvByte = '0;
  logic ackWanted = 1'b0;
  int baseRise = 0, baseFall = 0;
  int riseCnt = 0, fallCnt = 0, startCnt = 0, stopCnt = 0, cyc = 0;
  int lastStopCyc = 0, sclFallCyc = -100000, sdaChgCyc = -100000;
  int minLow = 1 << 30, minSetup = 1 << 30;
  bit measureOn = 1'b0;
  logic sclPrev = 1'b1, sdaPrev = 1'b1, sdaPullPrev = 1'b0;
  logic [7:0] wordSeen = '0;
  logic ninthSda = 1'b0;

  always_comb begin
    int k;
    k = fallCnt - baseFall;
    case (slvMode)
      1:       slvSdaLow = (k == 8) && ackWanted;
      2:       slvSdaLow = (k < 8) ? !((slvByte >> (7 - k)) & 8'd1) : 1'b0;
      default: slvSdaLow = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    int k;
    cyc <= cyc + 1;
    sclPrev <= sclLine;
    sdaPrev <= sdaLine;
    sdaPullPrev <= sdaPullLow;
    if (sdaPullLow != sdaPullPrev) sdaChgCyc <= cyc;
    if (rstN) begin
      if (sclLine && sclPrev && sdaPrev && !sdaLine) startCnt <= startCnt + 1;
      if (sclLine && sclPrev && !sdaPrev && sdaLine) begin
        stopCnt <= stopCnt + 1;
        lastStopCyc <= cyc;
      end
      if (sclLine && !sclPrev) begin
        k = riseCnt - baseRise;
        if (k < 8) wordSeen[7 - k] <= sdaLine;
        if (k == 8) ninthSda <= sdaLine;
        riseCnt <= riseCnt + 1;
        if (measureOn && (cyc - sclFallCyc) < minLow) minLow <= cyc - sclFallCyc;
        if (measureOn && (cyc - sdaChgCyc) < minSetup) minSetup <= cyc - sdaChgCyc;
      end
      if (!sclLine && sclPrev) begin
        fallCnt <= fallCnt + 1;
        sclFallCyc <= cyc;
      end
    end
  end

  int nChk = 0, nFail = 0;
  logic [7:0] rData;
  logic rNack, rStuck;
  int startCyc = 0, endCyc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAtLeast(input string req, input int act, input int lim);
    nChk++;
    if (act < lim) begin
      nFail++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [7:0] d, input int mode,
                       input logic [7:0] sb, input logic ack);
    @(negedge clk);
    check("R2 ready before command", {31'd0, cmdReady}, 32'd1);
    baseRise = riseCnt;
    baseFall = fallCnt;
    slvByte = sb;
    ackWanted = ack;
    slvMode = mode;
    cmdOp = op;
    cmdData = d;
    cmdValid = 1'b1;
    startCyc = cyc;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!doneValid) @(negedge clk);
    rData = doneData;
    rNack = doneNack;
    rStuck = doneStuck;
    endCyc = cyc;
    slvMode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    int s0, r0, f0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 sclPullLow", {31'd0, sclPullLow}, 32'd0);
    check("R1 sdaPullLow", {31'd0, sdaPullLow}, 32'd0);
    check("R1 cmdReady", {31'd0, cmdReady}, 32'd1);
    check("R1 doneValid", {31'd0, doneValid}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    measureOn = 1'b1;

    // R8: START
    doCmd(3'd0, 8'h00, 0, 8'h00, 1'b0);
    check("R8 start seen", startCnt, 1);
    check("R8 clock low after start", {31'd0, sclLine}, 32'd0);
    check("R4 nack zero off send", {31'd0, rNack}, 32'd0);

    // R3/R4: send sweep with alternating acknowledge
    for (int v = 0; v < 256; v += 3) begin
      doCmd(3'd2, 8'(v), 1, 8'h00, (v % 2) == 0);
      check("R3 byte on wire", {24'd0, wordSeen}, 32'(v));
      check("R4 nack flag", {31'd0, rNack}, {31'd0, (v % 2) != 0});
      check("R4 ninth clock level", {31'd0, ninthSda}, {31'd0, (v % 2) != 0});
    end

    // R5/R6: receive with acknowledge sweep
    for (int v = 0; v < 256; v += 3) begin
      doCmd(3'd3, 8'h00, 2, 8'(v), 1'b0);
      check("R5 received byte", {24'd0, rData}, 32'(v));
      check("R6 ack driven low", {31'd0, ninthSda}, 32'd0);
      check("R6 data released", {31'd0, sdaPullLow}, 32'd0);
    end

    // R7/R8: final receive ends with STOP and bus-free wait
    s0 = stopCnt;
    doCmd(3'd4, 8'h00, 2, 8'hA5, 1'b0);
    check("R5 final byte", {24'd0, rData}, 32'hA5);
    check("R7 ninth released", {31'd0, ninthSda}, 32'd1);
    check("R7 stop seen", stopCnt, s0 + 1);
    checkAtLeast("R8 bus free after final read", endCyc - lastStopCyc, 60 * CPU);

    // R8: START then STOP command
    doCmd(3'd0, 8'h00, 0, 8'h00, 1'b0);
    s0 = stopCnt;
    doCmd(3'd1, 8'h00, 0, 8'h00, 1'b0);
    check("R8 stop seen", stopCnt, s0 + 1);
    checkAtLeast("R8 bus free after stop", endCyc - lastStopCyc, 60 * CPU);
    check("R8 lines idle high", {30'd0, sclLine, sdaLine}, 32'd3);

    // R2: undefined codes finish with no line activity
    for (int op = 5; op < 8; op++) begin
      r0 = riseCnt;
      f0 = fallCnt;
      doCmd(3'(op), 8'h00, 0, 8'h00, 1'b0);
      check("R2 undefined code rises", riseCnt, r0);
      check("R2 undefined code falls", fallCnt, f0);
    end

    // R11: timing seen on the bus
    checkAtLeast("R11 clock low time", minLow, 2 * CPU);
    checkAtLeast("R11 data settle before rise", minSetup, 2 * CPU);

    // R9: short stretch tolerated
    doCmd(3'd0, 8'h00, 0, 8'h00, 1'b0);
    slvSclLow = 1'b1;
    fork
      doCmd(3'd2, 8'h3C, 1, 8'h00, 1'b1);
      begin repeat (800) @(negedge clk); slvSclLow = 1'b0; end
    join
    check("R9 no stuck on short stretch", {31'd0, rStuck}, 32'd0);
    check("R9 byte intact", {24'd0, wordSeen}, 32'h3C);
    check("R9 acked", {31'd0, rNack}, 32'd0);
    checkAtLeast("R9 transfer delayed", endCyc - startCyc, 800);

    // R10: stretch past the limit
    measureOn = 1'b0;
    slvSclLow = 1'b1;
    fork
      doCmd(3'd2, 8'h55, 1, 8'h00, 1'b1);
      begin repeat (4600) @(negedge clk); slvSclLow = 1'b0; end
    join
    check("R10 stuck flagged", {31'd0, rStuck}, 32'd1);
    doCmd(3'd2, 8'h81, 1, 8'h00, 1'b1);
    check("R10 stuck cleared", {31'd0, rStuck}, 32'd0);
    check("R10 later byte intact", {24'd0, wordSeen}, 32'h81);
    doCmd(3'd1, 8'h00, 0, 8'h00, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule